// File: doc/BRIEF.md
# Bit and Digit Ring Sequencer

This block converts a per-bit timing strobe, which in read mode follows the recovered clock-track phase, into character and operation timing. A bit ring steps once for each strobe. It starts at a bit-sync slot, walks through the data positions and then wraps back. At every data position it latches the sampled read bit into the matching position of a serial register. When the ring wraps, the assembled character is presented in parallel together with a one-cycle valid pulse. The bit-sync bit serves only for timing and is never part of the character.

The ring length follows a short/long mode select: seven bit times (sync plus six data bits) or nine bit times (sync plus eight data bits). The mode is sampled only at the start of a character. A digit ring advances once per completed character and cycles through thirteen positions. It supplies the timing that starts operations. When read timing is suspended, no strobes arrive and both rings hold. This includes the digit ring resting on its final position through a record gap. Dropping the run enable returns everything to its start state.

The character output has no back-pressure: the rings run at disk speed and cannot wait. The consumer must take `char_data` on the cycle `char_valid` is high. The data stays unchanged until the next character replaces it.

Top module: `bit_digit_sequencer`

## Requirements
- R1: After reset, and whenever run is enabled, the bit ring position moves by exactly one for each cycle in which `bit_stb` is high. Without a strobe it does not move.
- R2: Bit ring positions are numbered from 0, the bit-sync slot. In short mode the last position is 6 and in long mode it is 8. A strobe on the last position returns the ring to 0.
- R3: `mode_nine` (0 = short, 1 = long) is sampled only by the strobe taken in slot 0. A change at any other time does not alter the length of the character in progress.
- R4: `char_valid` is high for exactly one cycle, the cycle after the strobe that leaves the last position, provided `read_gate` was high with that strobe.
- R5: In `char_data`, the bit strobed at position p (p ≥ 1) lands at bit p-1, so the first data bit is bit 0. The slot-0 bit is discarded. Bits 7:6 are zero for a short character. The value holds until the next valid character.
- R6: The digit ring position advances by one each time the bit ring wraps. It counts 0 to 12 and returns to 0 after 12.
- R7: Without strobes, both rings hold their positions for any length of time, including the digit ring on position 12.
- R8: While `run_en` is low, both ring positions, the serial register, `char_valid` and `char_data` are cleared to zero on each clock, and strobes are ignored.
- R9: With `read_gate` low, the rings still step, but a wrap raises no `char_valid` and leaves `char_data` unchanged.
- R10: `bit_oh` has exactly the bit at index `bit_pos` set, and `digit_oh` has exactly the bit at index `digit_pos` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low clears the sequencer |
| read_gate | input | 1 | High while reading; enables character delivery |
| mode_nine | input | 1 | 0 = seven bit times per character, 1 = nine |
| bit_stb | input | 1 | One-cycle bit-time strobe from the selected phase |
| bit_in | input | 1 | Sampled read bit qualified by `bit_stb` |
| bit_pos | output | 4 | Bit ring position, 0 = bit-sync slot |
| bit_oh | output | 9 | Bit ring position, one-hot |
| char_valid | output | 1 | One-cycle pulse: new character on `char_data` |
| char_data | output | 8 | Assembled character, right-aligned |
| digit_pos | output | 4 | Digit ring position 0..12 |
| digit_oh | output | 13 | Digit ring position, one-hot |

## Verification
Every result is registered once, so a strobe, mode or run change applied before a rising edge shows on the ports just after that edge. The ring positions, the one-hot codes, the valid pulse, the character and the digit position are all due one clock after the stimulus. The bench applies each stimulus on a falling edge and lets one rising edge pass. It then compares every output on the next falling edge against a model advanced by the same stimulus. No result is ever looked for earlier or later than that single cycle.

// File: rtl/bds_pkg.sv
package bds_pkg;
  typedef enum logic {
    LEN_SHORT = 1'b0,
    LEN_LONG  = 1'b1
  } ring_len_e;

  function automatic int last_slot(input ring_len_e m, input int short_len, input int long_len);
    return (m == LEN_LONG) ? long_len - 1 : short_len - 1;
  endfunction
endpackage

// File: rtl/bds_bit_ring.sv
module bds_bit_ring
  import bds_pkg::*;
#(
  parameter int SHORT_LEN = 7,
  parameter int LONG_LEN  = 9,
  parameter int POS_W     = $clog2(LONG_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                mode_nine,
  input  logic                bit_stb,
  output logic [POS_W-1:0]    pos_o,
  output logic [LONG_LEN-1:0] oh_o,
  output logic                sync_o,
  output logic                step_o,
  output logic                wrap_o
);
  localparam logic [POS_W-1:0] SHORT_LAST = POS_W'(SHORT_LEN - 1);
  localparam logic [POS_W-1:0] LONG_LAST  = POS_W'(LONG_LEN - 1);

  logic [POS_W-1:0] pos_q;
  ring_len_e        len_q;
  logic             take;
  logic             at_last;

  assign take    = run_en && bit_stb;
  assign at_last = (pos_q == ((len_q == LEN_LONG) ? LONG_LAST : SHORT_LAST));
  assign sync_o  = take && (pos_q == '0);
  assign step_o  = take && (pos_q != '0);
  assign wrap_o  = step_o && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= LEN_SHORT;
    end else if (!run_en) begin
      pos_q <= '0;
      len_q <= LEN_SHORT;
    end else if (bit_stb) begin
      if (pos_q == '0) begin
        len_q <= mode_nine ? LEN_LONG : LEN_SHORT;
        pos_q <= POS_W'(1);
      end else if (at_last) begin
        pos_q <= '0;
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  for (genvar g = 0; g < LONG_LEN; g++) begin : g_oh
    assign oh_o[g] = (pos_q == POS_W'(g));
  end

  assign pos_o = pos_q;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !at_last) |=> (pos_q == $past(pos_q) + POS_W'(1)));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && at_last && pos_q != '0) |=> (pos_q == '0));
  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == LEN_SHORT && pos_q != '0) |-> (pos_q <= SHORT_LAST));
  p_len_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !sync_o) |=> $stable(len_q));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !bit_stb) |=> $stable(pos_q));
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oh_o) == 1);
endmodule

// File: rtl/bds_char_asm.sv
module bds_char_asm #(
  parameter int DATA_W = 8,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              read_gate,
  input  logic              bit_in,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              sync_i,
  input  logic              step_i,
  input  logic              wrap_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sreg_q;
  logic [DATA_W-1:0] sreg_d;

  for (genvar g = 0; g < DATA_W; g++) begin : g_cell
    always_comb begin
      if (sync_i)
        sreg_d[g] = 1'b0;
      else if (step_i && pos_i == POS_W'(g + 1))
        sreg_d[g] = bit_in;
      else
        sreg_d[g] = sreg_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (!run_en) begin
      sreg_q  <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      sreg_q  <= sreg_d;
      valid_o <= wrap_i && read_gate;
      if (wrap_i && read_gate)
        data_o <= sreg_d;
    end
  end

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !read_gate) |=> ($stable(data_o) && !valid_o));
  p_sync_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sync_i) |=> (sreg_q == '0));
endmodule

// File: rtl/bds_digit_ring.sv
module bds_digit_ring #(
  parameter int DIGIT_LEN = 13,
  parameter int DIG_W     = $clog2(DIGIT_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 adv_i,
  output logic [DIG_W-1:0]     pos_o,
  output logic [DIGIT_LEN-1:0] oh_o
);
  localparam logic [DIG_W-1:0] LAST = DIG_W'(DIGIT_LEN - 1);

  logic [DIG_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos_q <= '0;
    else if (!run_en)
      pos_q <= '0;
    else if (adv_i)
      pos_q <= (pos_q == LAST) ? '0 : pos_q + DIG_W'(1);
  end

  for (genvar g = 0; g < DIGIT_LEN; g++) begin : g_oh
    assign oh_o[g] = (pos_q == DIG_W'(g));
  end

  assign pos_o = pos_q;

  p_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && adv_i && pos_q != LAST) |=> (pos_q == $past(pos_q) + DIG_W'(1)));
  p_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && adv_i && pos_q == LAST) |=> (pos_q == '0));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !adv_i) |=> $stable(pos_q));
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oh_o) == 1);
endmodule

// File: rtl/bit_digit_sequencer.sv
module bit_digit_sequencer #(
  parameter int SHORT_LEN = 7,
  parameter int LONG_LEN  = 9,
  parameter int DIGIT_LEN = 13,
  localparam int POS_W    = $clog2(LONG_LEN),
  localparam int DIG_W    = $clog2(DIGIT_LEN),
  localparam int DATA_W   = LONG_LEN - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 read_gate,
  input  logic                 mode_nine,
  input  logic                 bit_stb,
  input  logic                 bit_in,
  output logic [POS_W-1:0]     bit_pos,
  output logic [LONG_LEN-1:0]  bit_oh,
  output logic                 char_valid,
  output logic [DATA_W-1:0]    char_data,
  output logic [DIG_W-1:0]     digit_pos,
  output logic [DIGIT_LEN-1:0] digit_oh
);
  logic sync_w;
  logic step_w;
  logic wrap_w;

  bds_bit_ring #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .POS_W(POS_W)
  ) u_bit_ring (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_nine(mode_nine),
    .bit_stb(bit_stb), .pos_o(bit_pos), .oh_o(bit_oh),
    .sync_o(sync_w), .step_o(step_w), .wrap_o(wrap_w)
  );

  bds_char_asm #(
    .DATA_W(DATA_W), .POS_W(POS_W)
  ) u_char_asm (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .read_gate(read_gate),
    .bit_in(bit_in), .pos_i(bit_pos), .sync_i(sync_w), .step_i(step_w),
    .wrap_i(wrap_w), .valid_o(char_valid), .data_o(char_data)
  );

  bds_digit_ring #(
    .DIGIT_LEN(DIGIT_LEN), .DIG_W(DIG_W)
  ) u_digit_ring (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .adv_i(wrap_w),
    .pos_o(digit_pos), .oh_o(digit_oh)
  );

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (bit_pos == '0 && digit_pos == '0 && !char_valid && char_data == '0));
  p_valid_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> (bit_pos == '0));
endmodule

// File: tb/bit_digit_sequencer_tb.sv
module bit_digit_sequencer_tb_top;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, read_gate = 1'b0, mode_nine = 1'b0;
  logic        bit_stb = 1'b0, bit_in = 1'b0;
  logic [3:0]  bit_pos;
  logic [8:0]  bit_oh;
  logic        char_valid;
  logic [7:0]  char_data;
  logic [3:0]  digit_pos;
  logic [12:0] digit_oh;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int m_pos = 0, m_len = 7, m_sreg = 0, m_dpos = 0, m_valid = 0, m_data = 0;

  always #(CLK_NS / 2) clk = ~clk;

  bit_digit_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .read_gate(read_gate),
    .mode_nine(mode_nine), .bit_stb(bit_stb), .bit_in(bit_in),
    .bit_pos(bit_pos), .bit_oh(bit_oh), .char_valid(char_valid),
    .char_data(char_data), .digit_pos(digit_pos), .digit_oh(digit_oh)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_digit(int d);
    return (d == 12) ? 0 : d + 1;
  endfunction

  task automatic model(bit run, bit rg, bit md, bit stb, bit b);
    if (!run) begin
      m_pos = 0; m_len = 7; m_sreg = 0; m_dpos = 0; m_valid = 0; m_data = 0;
      return;
    end
    m_valid = 0;
    if (!stb) return;
    if (m_pos == 0) begin
      m_len = md ? 9 : 7;
      m_sreg = 0;
      m_pos = 1;
    end else begin
      m_sreg = m_sreg | (int'(b) << (m_pos - 1));
      if (m_pos == m_len - 1) begin
        m_pos = 0;
        m_dpos = next_digit(m_dpos);
        if (rg) begin
          m_valid = 1;
          m_data = m_sreg;
        end
      end else begin
        m_pos++;
      end
    end
  endtask

  task automatic step(bit run, bit rg, bit md, bit stb, bit b, string ctx);
    run_en = run; read_gate = rg; mode_nine = md; bit_stb = stb; bit_in = b;
    model(run, rg, md, stb, b);
    @(posedge clk);
    @(negedge clk);
    check({ctx, "/R2"}, "bit_pos", int'(bit_pos), m_pos);
    check({ctx, "/R10"}, "bit_oh", int'(bit_oh), 1 << m_pos);
    check({ctx, "/R4"}, "char_valid", int'(char_valid), m_valid);
    check({ctx, "/R5"}, "char_data", int'(char_data), m_data);
    check({ctx, "/R6"}, "digit_pos", int'(digit_pos), m_dpos);
    check({ctx, "/R10"}, "digit_oh", int'(digit_oh), 1 << m_dpos);
  endtask

  task automatic send_char(bit md, bit rg, int bits, string ctx);
    int n = md ? 9 : 7;
    step(1, rg, md, 1, 1'b1, ctx);
    for (int i = 1; i < n; i++) step(1, rg, md, 1, bit'((bits >> (i - 1)) & 1), ctx);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", "reset bit_pos", int'(bit_pos), 0);
    check("R8", "reset char_data", int'(char_data), 0);
    check("R8", "reset digit_pos", int'(digit_pos), 0);
    rst_n = 1'b1;
    step(1, 1, 0, 0, 0, "R1");
    check("R1", "no-strobe pos", int'(bit_pos), 0);

    send_char(0, 1, 6'b101101, "R5");
    check("R5", "short char data", int'(char_data), 8'h2D);
    repeat (5) step(1, 1, 0, 0, 1, "R7");

    send_char(1, 1, 8'hB6, "R2");
    check("R5", "long char data", int'(char_data), 8'hB6);

    step(1, 1, 0, 1, 0, "R3");
    step(1, 1, 0, 1, 1, "R3");
    step(1, 1, 1, 1, 1, "R3");
    step(1, 1, 1, 1, 0, "R3");
    step(1, 1, 1, 1, 1, "R3");
    step(1, 1, 1, 1, 1, "R3");
    step(1, 1, 1, 1, 0, "R3");
    check("R3", "mode ignored mid-char, wrap at 6", int'(bit_pos), 0);
    check("R3", "short char after mid change", int'(char_data), 6'b011011);

    send_char(0, 0, 6'b111111, "R9");
    check("R9", "data held with gate low", int'(char_data), 6'b011011);

    while (m_dpos != 12) send_char(0, 1, int'($urandom_range(0, 63)), "R6");
    repeat (60) step(1, 1, 0, 0, 0, "R7");
    check("R7", "digit rests on 12", int'(digit_pos), 12);
    send_char(0, 1, 6'b000001, "R6");
    check("R6", "digit returns to 0", int'(digit_pos), 0);

    step(1, 1, 1, 1, 1, "R8");
    step(1, 1, 1, 1, 1, "R8");
    step(1, 1, 1, 1, 1, "R8");
    step(0, 1, 1, 1, 1, "R8");
    check("R8", "run low pos", int'(bit_pos), 0);
    step(0, 1, 1, 1, 1, "R8");
    check("R8", "strobe ignored while stopped", int'(bit_pos), 0);

    begin
      bit run = 1, rg = 1, md = 0;
      for (int i = 0; i < 6000; i++) begin
        if ($urandom_range(0, 39) == 0) md = ~md;
        if ($urandom_range(0, 99) == 0) rg = ~rg;
        run = ($urandom_range(0, 299) != 0);
        step(run, rg, md, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "RND");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule